// File: doc/BRIEF.md
# Page Write Controller with Status Polling

This block sits between a bus decoder and a nonvolatile byte array. It gathers byte-load strobes into a one-page staging buffer. Once loads stop arriving, it runs a self-timed programming interval and then copies the staged bytes into the array. The array is a behavioural memory inside the block. Its write port is also driven out so that the commit can be observed. A page is 2^PAGE_BITS bytes. The byte offset is the low PAGE_BITS address bits, and the remaining upper bits form the page tag.

A host may keep loading bytes for as long as each new load follows the previous accepted one within the load window. When no load comes within the window, programming starts. While programming is under way, reads do not return array data. They return a status byte. Its top bit is the complement of the top bit of the last byte loaded. Its next bit inverts on every read. Its remaining bits are zero. The host can poll either bit to find out when the cycle has finished.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy is low, rd_data is zero and arr_we is low.
- R2: A load while idle opens a page whose tag is ld_addr[ADDR_W-1:PAGE_BITS]. Later loads with the same tag are staged at offset ld_addr[PAGE_BITS-1:0]. A repeated offset keeps the newest data, and every staged byte reaches the array at {tag, offset}.
- R3: While collecting, a load whose tag differs from the open page is dropped and does not restart the load window.
- R4: A load that arrives up to WINDOW_CYC cycles after the previous accepted load is accepted. If no load is accepted for WINDOW_CYC cycles, busy rises at that edge.
- R5: busy stays high for exactly PROG_CYC + 2^PAGE_BITS cycles. During that time arr_we pulses once for each distinct staged offset and at no other time.
- R6: Loads presented while busy is high change neither the array nor the staged page.
- R7: A read while busy returns a status byte, at any address. Bit DATA_W-1 is the inverse of bit DATA_W-1 of the last accepted load, and bits DATA_W-3..0 are zero.
- R8: The first status read of a programming cycle returns bit DATA_W-2 set. Each later status read in the same cycle returns that bit inverted.
- R9: A read while idle or collecting returns the array byte at rd_addr on the cycle after rd_stb.
- R10: rd_data holds its value in cycles without rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Byte-load strobe |
| ld_addr | input | ADDR_W | Byte-load address |
| ld_data | input | DATA_W | Byte-load data |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data or status, one cycle after rd_stb |
| busy | output | 1 | Programming or commit in progress |
| arr_we | output | 1 | Array write enable during commit |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench fills every page with scrambled offsets and varying gaps, including a gap exactly equal to the window. A design with an off-by-one window would start programming early and lose bytes. The bench also measures the busy width cycle by cycle. It sends a foreign-tag load late in the window, which a design that restarts the timer on rejected loads would misplace. It overwrites a staged offset, so a design that commits the first value or commits twice fails the write count. It polls repeatedly and checks the inverted top bit and the alternating toggle bit against values worked out from the loaded data. It also issues loads during busy, which a leaky design would write into the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PG_IDLE    = 2'd0,
    PG_COLLECT = 2'd1,
    PG_PROGRAM = 2'd2,
    PG_COMMIT  = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgw_cycle_timer.sv
module pgw_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && !restart && (cnt_q == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
  parameter int PAGE_BITS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [PAGE_BITS-1:0] widx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 clr,
  input  logic [PAGE_BITS-1:0] ridx,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid
);
  localparam int BYTES = 1 << PAGE_BITS;

  logic [DATA_W-1:0] slot [BYTES];
  logic [BYTES-1:0]  filled_q;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled_q <= '0;
    else if (we) filled_q[widx] <= 1'b1;
  end

  assign rdata  = slot[ridx];
  assign rvalid = filled_q[ridx];
endmodule

// File: rtl/pgw_byte_array.sv
module pgw_byte_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rq;

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rq <= '0;
    else if (rd_en) rq <= cells[raddr];
  end

  assign rdata = rq;
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BITS  = 6,
  parameter int WINDOW_CYC = 16,
  parameter int PROG_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int TAG_W = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_BITS-1:0] LAST_IDX = {PAGE_BITS{1'b1}};

  pg_state_e            state_q;
  logic [TAG_W-1:0]     tag_q;
  logic                 last_msb_q;
  logic [PAGE_BITS-1:0] commit_idx_q;
  logic                 tog_q;
  logic                 stat_sel_q;
  logic [DATA_W-1:0]    stat_q;

  logic             idle, collecting, programming, committing;
  logic [TAG_W-1:0] ld_tag;
  logic             accept, win_expired, prog_done, commit_last;
  logic [DATA_W-1:0] buf_rdata, arr_rq;
  logic             buf_rvalid;

  assign idle        = (state_q == PG_IDLE);
  assign collecting  = (state_q == PG_COLLECT);
  assign programming = (state_q == PG_PROGRAM);
  assign committing  = (state_q == PG_COMMIT);
  assign ld_tag      = ld_addr[ADDR_W-1:PAGE_BITS];
  assign accept      = ld_stb && (idle || (collecting && ld_tag == tag_q));
  assign commit_last = committing && (commit_idx_q == LAST_IDX);
  assign busy        = programming || committing;

  pgw_cycle_timer #(.LIMIT(WINDOW_CYC)) u_win (
    .clk(clk), .rst(rst), .restart(accept), .run(collecting),
    .expired(win_expired)
  );

  pgw_cycle_timer #(.LIMIT(PROG_CYC)) u_prog (
    .clk(clk), .rst(rst), .restart(!programming), .run(programming),
    .expired(prog_done)
  );

  pgw_page_buffer #(.PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .we(accept), .widx(ld_addr[PAGE_BITS-1:0]),
    .wdata(ld_data), .clr(commit_last), .ridx(commit_idx_q),
    .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  assign arr_we    = committing && buf_rvalid;
  assign arr_addr  = {tag_q, commit_idx_q};
  assign arr_wdata = buf_rdata;

  pgw_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .rd_en(rd_stb), .raddr(rd_addr), .rdata(arr_rq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PG_IDLE;
      tag_q        <= '0;
      last_msb_q   <= 1'b0;
      commit_idx_q <= '0;
      tog_q        <= 1'b0;
      stat_sel_q   <= 1'b0;
      stat_q       <= '0;
    end else begin
      if (accept) last_msb_q <= ld_data[DATA_W-1];
      unique case (state_q)
        PG_IDLE: if (accept) begin
          state_q <= PG_COLLECT;
          tag_q   <= ld_tag;
        end
        PG_COLLECT: if (win_expired) begin
          state_q <= PG_PROGRAM;
          tog_q   <= 1'b0;
        end
        PG_PROGRAM: if (prog_done) begin
          state_q      <= PG_COMMIT;
          commit_idx_q <= '0;
        end
        PG_COMMIT: begin
          commit_idx_q <= commit_idx_q + 1'b1;
          if (commit_last) state_q <= PG_IDLE;
        end
        default: state_q <= PG_IDLE;
      endcase
      if (rd_stb) begin
        stat_sel_q <= busy;
        stat_q     <= {~last_msb_q, ~tog_q, {(DATA_W-2){1'b0}}};
        if (busy) tog_q <= ~tog_q;
      end
    end
  end

  assign rd_data = stat_sel_q ? stat_q : arr_rq;

  // R8
  toggle_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_stb) ##1 (busy && rd_stb) |=>
      (rd_data[DATA_W-2] != $past(rd_data[DATA_W-2])));

  // R7
  status_low_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_stb) |=> (rd_data[DATA_W-3:0] == '0));

  // R6
  busy_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ld_stb) |=> ($stable(tag_q) && $stable(last_msb_q)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(arr_addr[PAGE_BITS-1:0]) == LAST_IDX));
endmodule

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;
  localparam int AW = 10, DW = 8, PB = 6, W = 16, P = 40;
  localparam int PAGE = 1 << PB, DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_stb = 0, rd_stb = 0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] rd_data, arr_wdata;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;

  int errors = 0, checks = 0, we_cnt = 0, cyc = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB),
                    .WINDOW_CYC(W), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst && arr_we) we_cnt++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R5 watchdog: actual cycles=%0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input int a, input int d);
    ld_stb = 1; ld_addr = AW'(a); ld_data = DW'(d);
    @(negedge clk);
    ld_stb = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    rd_stb = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_stb = 0;
    v = rd_data;
  endtask

  // after the last accepted load: window edge check, then busy width check
  task automatic finish_page(input string tag);
    int n;
    idle(W - 1);
    chk({"R4 no-early-start ", tag}, busy, 0);
    idle(1);
    chk({"R4 start-at-window ", tag}, busy, 1);
    n = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk({"R5 busy-width ", tag}, n, P + PAGE);
  endtask

  initial begin
    logic [DW-1:0] v;
    int base, off, d, a;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    idle(3);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 arr_we", arr_we, 0);
    rst = 0;
    idle(2);
    chk("R1 busy after release", busy, 0);

    // single byte with status polling: R7 R8
    load(12'h085, 8'hA5); model[12'h085] = 8'hA5;
    idle(W);
    chk("R4 single byte start", busy, 1);
    rd(12'h085, v); chk("R7 R8 poll 1", v, 8'h40);
    rd(12'h085, v); chk("R7 R8 poll 2", v, 8'h00);
    rd(12'h085, v); chk("R7 R8 poll 3", v, 8'h40);
    rd(12'h300, v); chk("R7 other address", v, 8'h00);
    idle(2);
    chk("R10 hold", rd_data, 8'h00);
    while (busy) @(negedge clk);
    rd(12'h085, v); chk("R9 after commit", v, 8'hA5);
    chk("R5 single write count", we_cnt, 1);
    idle(3);
    chk("R10 hold idle", rd_data, 8'hA5);

    // every page full, scrambled offsets, gaps 1..W: R2 R4 R5
    for (int p = 0; p < DEPTH / PAGE; p++) begin
      base = we_cnt;
      for (int i = 0; i < PAGE; i++) begin
        off = (i * 37) % PAGE;
        a = p * PAGE + off;
        d = ((a * 7) + 3) & 8'hFF;
        if (i != 0) idle((i % W));
        load(a, d);
        model[a] = DW'(d);
      end
      finish_page($sformatf("page %0d", p));
      chk($sformatf("R5 page %0d write count", p), we_cnt - base, PAGE);
    end
    for (int a2 = 0; a2 < DEPTH; a2++) begin
      rd(a2, v);
      chk($sformatf("R2 R9 content %0h", a2), v, model[a2]);
    end

    // overwrite of a staged offset: R2, polling bit from last data: R7
    base = we_cnt;
    load(3 * PAGE + 8'h10, 8'h11);
    load(3 * PAGE + 8'h10, 8'h99);
    load(3 * PAGE + 8'h20, 8'h22);
    model[3 * PAGE + 8'h10] = 8'h99; model[3 * PAGE + 8'h20] = 8'h22;
    idle(W);
    rd(3 * PAGE + 8'h20, v); chk("R7 poll inverted msb", v, 8'hC0);
    while (busy) @(negedge clk);
    chk("R2 R5 overwrite count", we_cnt - base, 2);
    rd(3 * PAGE + 8'h10, v); chk("R2 newest data", v, 8'h99);
    rd(3 * PAGE + 8'h20, v); chk("R2 second byte", v, 8'h22);

    // foreign tag late in window: R3; loads while busy: R6
    base = we_cnt;
    load(4 * PAGE + 1, 8'h5A); model[4 * PAGE + 1] = 8'h5A;
    idle(W - 3);
    load(5 * PAGE + 1, 8'hEE);
    idle(1);
    chk("R3 window not restarted (low)", busy, 0);
    idle(1);
    chk("R3 window not restarted (high)", busy, 1);
    load(5 * PAGE + 2, 8'h00);
    load(4 * PAGE + 3, 8'h00);
    while (busy) @(negedge clk);
    chk("R3 R6 write count", we_cnt - base, 1);
    rd(5 * PAGE + 1, v); chk("R3 foreign byte dropped", v, model[5 * PAGE + 1]);
    rd(5 * PAGE + 2, v); chk("R6 busy load dropped", v, model[5 * PAGE + 2]);
    rd(4 * PAGE + 3, v); chk("R6 busy same page dropped", v, model[4 * PAGE + 3]);
    rd(4 * PAGE + 1, v); chk("R2 accepted byte", v, 8'h5A);
    idle(2);
    chk("R1 no stray start", busy, 0);

    summary();
    $finish;
  end
endmodule